// File: doc/BRIEF.md
# UART Receiver Sleep and Wakeup Controller

This block runs next to a UART receiver and owns the receiver's sleep flag. Software sets the flag when the traffic on a shared serial line is meant for some other node. While the flag is set, the receive-data event for finished characters is held back. The block clears the flag on its own, using one of two wakeup methods that software selects.

In idle wakeup, the block counts bit times during which the line stays high. The flag clears as soon as one full character time of idle has been seen. A character time covers the start bit, the data bits and the stop bit. The counting can be armed in two ways. In the first, it runs from the start bit onward, so the stop bit and any high data bits at the end of a character count toward the idle time. In the second, counting begins only after the stop bit, so the content of the last character has no effect on it.

In address wakeup, the flag clears when a received character has its top data bit set. That character is passed on as a normal received character. The receiver supplies the line level, a bit-time tick, start-bit and stop-bit strobes, and the finished character. Baud generation, sampling and noise filtering belong to the receiver.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After reset, sleep_o is 0 and rx_event_o is 0.
- R2: A pulse on sleep_set_i makes sleep_o read 1 from the next clock. On that same clock, any partial idle count is discarded, so a full character time of idle is needed again afterwards.
- R3: With wake_mode_i = 0 and nine_bit_i = 0, sleep_o clears on the clock edge of the bit tick that completes DATA_BITS+2 (10 by default) consecutive high ticks, and not one tick earlier.
- R4: With wake_mode_i = 0 and nine_bit_i = 1, the idle length needed is DATA_BITS+3 (11 by default) ticks.
- R5: A bit tick with line_i = 0 sets the idle count back to zero.
- R6: With idle_after_stop_i = 0, the stop-bit tick and the high data bits at the end of a character count toward idle. After a character whose top data bits hold t consecutive ones, the number of further idle ticks needed is the character time minus t minus 1.
- R7: With idle_after_stop_i = 1, no tick between the start-bit strobe and the stop-bit strobe counts. The stop tick itself does not count either, so a full character time of ticks is needed after every character.
- R8: With wake_mode_i = 1, a stop strobe whose character has its top bit set clears sleep_o on that clock. The top bit is char_i[DATA_BITS-1] (bit 7) when nine_bit_i = 0 and char_i[DATA_BITS] (bit 8) when nine_bit_i = 1.
- R9: With wake_mode_i = 1, a character whose top bit is 0 leaves sleep_o set, and so does any length of idle line. With wake_mode_i = 0, a character with its top bit set does not clear sleep_o.
- R10: rx_event_o is high in the cycle of a stop strobe if sleep_o is 0, or if that character wakes the receiver under R8. Otherwise it stays low.
- R11: If sleep_set_i is high in the same cycle as a waking event, sleep_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled serial line level |
| bit_tick_i | input | 1 | One pulse per bit time, at the sample point |
| start_bit_i | input | 1 | Start-bit strobe, asserted with its bit tick |
| stop_bit_i | input | 1 | Stop-bit strobe, asserted with its bit tick; char_i valid |
| char_i | input | DATA_BITS+1 | Received character, bit 0 first on the line |
| nine_bit_i | input | 1 | 1 selects the long data length (DATA_BITS+1 bits) |
| wake_mode_i | input | 1 | 0 selects idle wakeup, 1 selects address wakeup |
| idle_after_stop_i | input | 1 | 0 counts idle from the start bit, 1 counts from after the stop bit |
| sleep_set_i | input | 1 | Software pulse that sets the sleep flag |
| sleep_o | output | 1 | Sleep flag |
| rx_event_o | output | 1 | Receive-data event, not raised while asleep |

## Verification
The bench uses the default DATA_BITS = 8, so both data lengths can be swept completely. All 256 eight-bit values and all 512 nine-bit values are sent under both idle-counting options. For each character, the bench counts the idle ticks needed to wake and compares that count with an arithmetic prediction based on the character's run of high top bits. The same full value sets are then sent in address mode. In eight-bit mode, the unused ninth bit is driven opposite to bit 7, which shows that the correct bit position decides each wakeup and each receive event.

// File: rtl/rx_wake_pkg.sv
package rx_wake_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    typedef enum logic {
        IDLE_FROM_START = 1'b0,
        IDLE_FROM_STOP  = 1'b1
    } idle_start_e;

    typedef struct packed {
        logic sleep;
    } ctrl_state_t;

endpackage

// File: rtl/rx_idle_counter.sv
module rx_idle_counter
    import rx_wake_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic long_i,
    input  logic from_stop_i,
    input  logic clear_i,
    output logic hit_o
);
    localparam int FRAME_SHORT = DATA_BITS + 2;
    localparam int FRAME_LONG  = DATA_BITS + 3;
    localparam int CNT_W       = $clog2(FRAME_LONG + 1);
    localparam logic [CNT_W-1:0] THR_SHORT = CNT_W'(FRAME_SHORT);
    localparam logic [CNT_W-1:0] THR_LONG  = CNT_W'(FRAME_LONG);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } idle_state_t;

    idle_state_t st_d, st_q;
    logic [CNT_W-1:0] thr;
    logic             counting;

    always_comb begin
        st_d     = st_q;
        hit_o    = 1'b0;
        thr      = long_i ? THR_LONG : THR_SHORT;
        counting = (idle_start_e'(from_stop_i) == IDLE_FROM_START) || st_q.armed;
        if (start_i) st_d.armed = 1'b0;
        if (stop_i)  st_d.armed = 1'b1;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (!line_i) begin
                st_d.cnt = '0;
            end else if (counting && (st_q.cnt < thr)) begin
                st_d.cnt = st_q.cnt + 1'b1;
                hit_o    = ((st_q.cnt + 1'b1) == thr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= THR_LONG);

    // R5
    low_line_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !line_i) |=> (st_q.cnt == '0));

    // R2
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0));

    // R7
    no_count_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (from_stop_i && start_i && !stop_i) |=> !st_q.armed);

endmodule

// File: rtl/rx_addr_mark.sv
module rx_addr_mark #(
    parameter int DATA_BITS = 8
) (
    input  logic [DATA_BITS:0] char_i,
    input  logic               long_i,
    output logic               mark_o
);
    localparam int TOP_SHORT = DATA_BITS - 1;
    localparam int TOP_LONG  = DATA_BITS;

    always_comb begin
        mark_o = long_i ? char_i[TOP_LONG] : char_i[TOP_SHORT];
    end

endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl
    import rx_wake_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    input  logic               bit_tick_i,
    input  logic               start_bit_i,
    input  logic               stop_bit_i,
    input  logic [DATA_BITS:0] char_i,
    input  logic               nine_bit_i,
    input  logic               wake_mode_i,
    input  logic               idle_after_stop_i,
    input  logic               sleep_set_i,
    output logic               sleep_o,
    output logic               rx_event_o
);
    ctrl_state_t st_d, st_q;
    logic        idle_hit;
    logic        mark;
    logic        addr_mode;
    logic        addr_wake;

    rx_idle_counter #(.DATA_BITS(DATA_BITS)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (bit_tick_i),
        .line_i      (line_i),
        .start_i     (start_bit_i),
        .stop_i      (stop_bit_i),
        .long_i      (nine_bit_i),
        .from_stop_i (idle_after_stop_i),
        .clear_i     (sleep_set_i),
        .hit_o       (idle_hit)
    );

    rx_addr_mark #(.DATA_BITS(DATA_BITS)) u_mark (
        .char_i (char_i),
        .long_i (nine_bit_i),
        .mark_o (mark)
    );

    always_comb begin
        st_d      = st_q;
        addr_mode = (wake_mode_e'(wake_mode_i) == WAKE_ADDR);
        addr_wake = addr_mode && stop_bit_i && mark;
        if (sleep_set_i) begin
            st_d.sleep = 1'b1;
        end else if (st_q.sleep && addr_wake) begin
            st_d.sleep = 1'b0;
        end else if (st_q.sleep && !addr_mode && idle_hit) begin
            st_d.sleep = 1'b0;
        end
        rx_event_o = stop_bit_i && (!st_q.sleep || addr_wake);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sleep <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sleep_o = st_q.sleep;

    // R2
    set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_set_i |=> sleep_o);

    // R2
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(sleep_set_i));

    // R8
    addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_mode_i && stop_bit_i && mark && !sleep_set_i) |=> !sleep_o);

    // R10
    asleep_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !wake_mode_i) |-> !rx_event_o);

    // R9
    addr_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_mode_i && !stop_bit_i) |=> sleep_o);

endmodule

// File: tb/rx_wake_ctrl_test.sv
module rx_wake_ctrl_test;
    localparam int DATA_BITS = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               line_i = 1'b1;
    logic               bit_tick_i = 1'b0;
    logic               start_bit_i = 1'b0;
    logic               stop_bit_i = 1'b0;
    logic [DATA_BITS:0] char_i = '0;
    logic               nine_bit_i = 1'b0;
    logic               wake_mode_i = 1'b0;
    logic               idle_after_stop_i = 1'b0;
    logic               sleep_set_i = 1'b0;
    logic               sleep_o;
    logic               rx_event_o;

    int  tests = 0;
    int  fails = 0;
    int  cycles = 0;
    bit  done = 1'b0;
    logic ev_s;

    rx_wake_ctrl #(.DATA_BITS(DATA_BITS)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .bit_tick_i(bit_tick_i),
        .start_bit_i(start_bit_i), .stop_bit_i(stop_bit_i), .char_i(char_i),
        .nine_bit_i(nine_bit_i), .wake_mode_i(wake_mode_i),
        .idle_after_stop_i(idle_after_stop_i), .sleep_set_i(sleep_set_i),
        .sleep_o(sleep_o), .rx_event_o(rx_event_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ln, input logic tk, input logic st, input logic sp,
                       input logic set, input logic [DATA_BITS:0] ch);
        @(negedge clk);
        line_i = ln; bit_tick_i = tk; start_bit_i = st; stop_bit_i = sp;
        sleep_set_i = set; char_i = ch;
        #5 ev_s = rx_event_o;
        @(posedge clk);
        #2;
    endtask

    task automatic quiet();
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic go_sleep();
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    endtask

    task automatic send_frame(input logic [DATA_BITS:0] ch, input logic set_at_stop,
                              output logic ev);
        int n;
        n = nine_bit_i ? DATA_BITS + 1 : DATA_BITS;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < n; i++) cyc(ch[i], 1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, set_at_stop, ch);
        ev = ev_s;
    endtask

    task automatic ticks_to_wake(output int k);
        k = 0;
        while (sleep_o && k < 40) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            k++;
        end
    endtask

    initial begin
        logic ev;
        int   k, exp_k, n, t, frame;
        logic [DATA_BITS:0] ch;

        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(sleep_o == 1'b0, "R1 sleep after reset", sleep_o, 0);
        chk(rx_event_o == 1'b0, "R1 event after reset", rx_event_o, 0);
        rst_n = 1'b1;
        quiet();

        // R2 set takes effect next clock
        go_sleep();
        chk(sleep_o == 1'b1, "R2 set effect", sleep_o, 1);

        // R3 exact 10-tick idle in 8-bit mode (one short stays asleep)
        for (int i = 0; i < DATA_BITS + 1; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk(sleep_o == 1'b1, "R3 one tick short", sleep_o, 1);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk(sleep_o == 1'b0, "R3 full idle wakes", sleep_o, 0);

        // R2 partial count discarded by a new set
        go_sleep();
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        go_sleep();
        ticks_to_wake(k);
        chk(k == DATA_BITS + 2, "R2 partial count cleared", k, DATA_BITS + 2);

        // R5 low sample resets the count
        go_sleep();
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        ticks_to_wake(k);
        chk(k == DATA_BITS + 2, "R5 low tick resets", k, DATA_BITS + 2);

        // R4 nine-bit idle length
        nine_bit_i = 1'b1;
        go_sleep();
        ticks_to_wake(k);
        chk(k == DATA_BITS + 3, "R4 nine-bit idle", k, DATA_BITS + 3);

        // R10 event while awake
        nine_bit_i = 1'b0;
        send_frame(9'h055, 1'b0, ev);
        chk(ev == 1'b1, "R10 event while awake", ev, 1);

        // R6 / R7 / R9 / R10 idle-mode sweep over every character
        for (int nb = 0; nb < 2; nb++) begin
            for (int ilt = 0; ilt < 2; ilt++) begin
                nine_bit_i = nb[0];
                idle_after_stop_i = ilt[0];
                n = nb ? DATA_BITS + 1 : DATA_BITS;
                frame = n + 2;
                for (int v = 0; v < (1 << n); v++) begin
                    ch = (DATA_BITS + 1)'(v);
                    go_sleep();
                    send_frame(ch, 1'b0, ev);
                    t = 0;
                    for (int b = n - 1; b >= 0 && ch[b]; b--) t++;
                    exp_k = ilt ? frame : frame - t - 1;
                    chk(sleep_o == 1'b1, "R9 idle mode ignores mark", sleep_o, 1);
                    chk(ev == 1'b0, "R10 no event asleep", ev, 0);
                    ticks_to_wake(k);
                    chk(k == exp_k, ilt ? "R7 idle after stop" : "R6 idle from start", k, exp_k);
                end
            end
        end

        // R8 / R9 / R10 address-mode sweep
        wake_mode_i = 1'b1;
        idle_after_stop_i = 1'b0;
        for (int nb = 0; nb < 2; nb++) begin
            nine_bit_i = nb[0];
            n = nb ? DATA_BITS + 1 : DATA_BITS;
            for (int v = 0; v < (1 << n); v++) begin
                ch = (DATA_BITS + 1)'(v);
                if (!nb) ch[DATA_BITS] = ~ch[DATA_BITS-1];
                go_sleep();
                send_frame(ch, 1'b0, ev);
                if (ch[n-1]) begin
                    chk(sleep_o == 1'b0, "R8 address mark wakes", sleep_o, 0);
                    chk(ev == 1'b1, "R10 waking char delivered", ev, 1);
                end else begin
                    chk(sleep_o == 1'b1, "R9 no mark stays asleep", sleep_o, 1);
                    chk(ev == 1'b0, "R10 no event asleep", ev, 0);
                end
            end
        end

        // R9 long idle does not wake in address mode
        nine_bit_i = 1'b0;
        go_sleep();
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk(sleep_o == 1'b1, "R9 idle ignored in address mode", sleep_o, 1);

        // R11 set wins over a same-cycle address wake
        send_frame(9'h080, 1'b1, ev);
        chk(sleep_o == 1'b1, "R11 set beats wake", sleep_o, 1);

        // R11 set wins over a same-cycle idle wake
        wake_mode_i = 1'b0;
        go_sleep();
        for (int i = 0; i < DATA_BITS + 1; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        chk(sleep_o == 1'b1, "R11 set beats idle wake", sleep_o, 1);

        quiet();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule